// File: doc/BRIEF.md
# Configuration Address/Data Port Controller

This block sits on the host side of an I/O bus and provides indirect access to a small table of per-function configuration spaces. Software writes a 32-bit address word into an address port one byte lane at a time (or in wider accesses that are split into lanes). The block decodes that word into a 16-bit bus/device/function index and a dword-aligned register offset. A write that reaches the top byte lane of the address port launches a lookup. The lookup captures a response dword and a present/absent status word.

Reads of the data port return bytes of the captured response. Reads of the address port return bytes of the status word, not the stored address. Writes to the data port of 8, 16 or 32 bits are merged into the addressed function's configuration storage. The lane offset of the access is added to the latched register offset.

A particular two-step bit pattern written to address byte lane 1 does not change the address. Instead it raises a one-cycle system reset request. The function table holds `NUM_SLOTS` slots, each of `SPACE_DWORDS` dwords. Slot `n` answers bus 0, device `n`, function 0, provided bit `n` of `PRESENT_MASK` is set.

Top module: `cfgp_port_ctrl`

## Requirements
- R1: A write to address byte lane 0 stores the byte with its two low bits forced to 0, so the register offset is always dword aligned.
- R2: The response and status words change only on a clock edge where an address-port write covers byte lane 3. Writes to address lanes 0 to 2 and all data-port writes leave them unchanged.
- R3: The index is {address byte 2, address byte 1}, with the device number in index bits [7:3] and the function number in bits [2:0]. When a lookup finds a present slot, the status word becomes 32'h8000_0000 and the response becomes the stored dword at offset[7:2].
- R4: A lookup that finds no slot sets the response to 32'hFFFF_FFFF and the status word to 0. No slot exists for a nonzero bus byte, a nonzero function number, a device number of NUM_SLOTS or above, or a device whose PRESENT_MASK bit is 0.
- R5: For a present slot whose offset[7:2] is SPACE_DWORDS or above, a lookup returns response 0 with status 32'h8000_0000, and data-port writes to that offset are discarded.
- R6: Let the stored byte 1 have bits [2:1] equal to 2'b01. A write to byte lane 1 whose new byte has bits [2:1] equal to 2'b11 then leaves byte 1 unchanged and drives sys_reset_req high for exactly one cycle after the write edge. The other lanes of that access are applied normally.
- R7: A data-port write at lane L (io_lane) writes into byte L of the addressed dword: a byte write at any lane, a 16-bit write at lanes 0 or 2 covering bytes L and L+1, or a 32-bit write at lane 0. The value is taken right-aligned from io_wdata. io_size encodes 0 = byte, 1 = 16-bit, 2 = 32-bit.
- R8: io_rdata equals the selected word shifted right by 8*io_lane. The selected word is the response when io_port_sel = 1 (data port) and the status word when io_port_sel = 0 (address port).
- R9: After reset, the address, response and status registers and all configuration storage are 0, and sys_reset_req is low.
- R10: Data-port writes while the address selects no slot change no stored dword.
- R11: Address bits [31:24], including the enable bit 31, have no effect: a byte-3 write launches the lookup whatever its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Write strobe for one access this cycle |
| io_port_sel | input | 1 | 0 = address port, 1 = data port |
| io_lane | input | 2 | Byte lane offset of the access within the port |
| io_size | input | 2 | Access width: 0 byte, 1 16-bit, 2 32-bit |
| io_wdata | input | 32 | Right-aligned write value |
| io_rdata | output | 32 | Status or response word shifted down by the lane |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume a legal bus master. io_size is never 3. A 16-bit data-port access uses lane 0 or 2, and a 32-bit one uses lane 0. An address-port access never runs past byte lane 3. The stimulus builds every access from a small set of tasks that only emit these combinations. The reset pattern is approached both through single-byte writes and through a full-width address write. The sequences that only resemble the pattern (prior bits not 01, or already 11) are driven as well.

// File: rtl/cfgp_pkg.sv
// Shared types and helpers for the configuration port controller.
// Assumes byte lanes are numbered 0..3 within a 32-bit port.
package cfgp_pkg;

    typedef enum logic [1:0] {
        IO_BYTE = 2'd0,
        IO_HALF = 2'd1,
        IO_WORD = 2'd2
    } io_size_e;

    localparam logic [31:0] STATUS_FOUND = 32'h8000_0000;
    localparam logic [31:0] RESP_NONE    = 32'hFFFF_FFFF;

    // Byte lanes touched by an access of the given width starting at lane.
    function automatic logic [3:0] lane_mask(input logic [1:0] lane, input logic [1:0] size);
        logic [3:0] base;
        case (size)
            IO_HALF: base = 4'b0011;
            IO_WORD: base = 4'b1111;
            default: base = 4'b0001;
        endcase
        return base << lane;
    endfunction

endpackage

// File: rtl/cfgp_addr_reg.sv
// Address latch: holds address bytes 0..2, launches a lookup when lane 3
// is written, and detects the byte-1 reset-request pattern.
// Assumes the access never extends past lane 3 (legal bus master).
module cfgp_addr_reg
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output logic [23:0] addr_q,
    output logic [23:0] addr_next,
    output logic        lookup_go,
    output logic        reset_pulse
);

    logic [3:0]  be;
    logic [23:0] lane_data;
    logic        reboot_hit;

    // Place the write value on its lanes and form the next address.
    always_comb begin
        be         = lane_mask(lane, size);
        lane_data  = 24'(wdata << {lane, 3'b000});
        reboot_hit = wr_en && be[1] && (addr_q[10:9] == 2'b01) && (lane_data[10:9] == 2'b11);
        addr_next  = addr_q;
        if (wr_en) begin
            if (be[0])               addr_next[7:0]   = {lane_data[7:2], 2'b00};
            if (be[1] && !reboot_hit) addr_next[15:8] = lane_data[15:8];
            if (be[2])               addr_next[23:16] = lane_data[23:16];
        end
        lookup_go = wr_en && be[3];
    end

    // Register the address and the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            reset_pulse <= 1'b0;
        end else begin
            addr_q      <= addr_next;
            reset_pulse <= reboot_hit;
        end
    end

endmodule

// File: rtl/cfgp_func_decode.sv
// Maps a bus/device/function index and dword offset onto a table slot.
// Slot n answers bus 0, device n, function 0 when PRESENT_MASK[n] is set.
module cfgp_func_decode #(
    parameter int                   NUM_SLOTS    = 4,
    parameter int                   SPACE_DWORDS = 64,
    parameter int                   SLOT_W       = 2,
    parameter logic [NUM_SLOTS-1:0] PRESENT_MASK = 4'b1011
) (
    input  logic [15:0]       bdf,
    input  logic [5:0]        dword,
    output logic              present,
    output logic [SLOT_W-1:0] slot,
    output logic              in_range
);

    localparam logic [6:0] LIMIT = 7'(SPACE_DWORDS);

    logic [NUM_SLOTS-1:0] hit;

    // One match term per slot.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign hit[i] = PRESENT_MASK[i] && (bdf[15:8] == 8'h00) &&
                        (bdf[2:0] == 3'b000) && (bdf[7:3] == 5'(i));
    end

    // Collapse the matches and check the offset against the space size.
    always_comb begin
        present  = |hit;
        slot     = bdf[3 +: SLOT_W];
        in_range = {1'b0, dword} < LIMIT;
    end

endmodule

// File: rtl/cfgp_write_shaper.sv
// Turns a right-aligned data-port write into lane enables and lane data.
// Register-specific write policy would hook in here; this version merges
// the written bytes as they are.
module cfgp_write_shaper
    import cfgp_pkg::*;
(
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output logic [3:0]  be,
    output logic [31:0] data
);

    // Shift the value up to its starting lane.
    always_comb begin
        be   = lane_mask(lane, size);
        data = wdata << {lane, 3'b000};
    end

endmodule

// File: rtl/cfgp_space_mem.sv
// Per-slot configuration storage built from flops, byte-writable,
// with one asynchronous read port. Assumes SPACE_DWORDS <= 64.
module cfgp_space_mem #(
    parameter int NUM_SLOTS    = 4,
    parameter int SPACE_DWORDS = 64,
    parameter int SLOT_W       = 2,
    parameter int DW_W         = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DW_W-1:0]   wr_dword,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [DW_W-1:0]   rd_dword,
    output logic [31:0]       rd_data
);

    logic [NUM_SLOTS-1:0][31:0] slot_rd;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_row
        logic [31:0] row [SPACE_DWORDS];

        // Clear on reset, otherwise merge enabled bytes into the target dword.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int d = 0; d < SPACE_DWORDS; d++) row[d] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                for (int b = 0; b < 4; b++) begin
                    if (wr_be[b]) row[wr_dword][8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end

        assign slot_rd[s] = row[rd_dword];
    end

    // Select the addressed slot's dword.
    always_comb rd_data = slot_rd[rd_slot];

endmodule

// File: rtl/cfgp_port_ctrl.sv
// Top of the configuration address/data port controller. An address-port
// write reaching lane 3 captures response and status from the table in the
// same edge; data-port writes go to the slot chosen by the latched address.
// Assumes at most one access per cycle and legal widths/lanes.
module cfgp_port_ctrl
    import cfgp_pkg::*;
#(
    parameter int                   NUM_SLOTS    = 4,
    parameter int                   SPACE_DWORDS = 64,
    parameter logic [NUM_SLOTS-1:0] PRESENT_MASK = 4'b1011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic        io_port_sel,
    input  logic [1:0]  io_lane,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        sys_reset_req
);

    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int DW_W   = (SPACE_DWORDS > 1) ? $clog2(SPACE_DWORDS) : 1;

    logic [23:0]       addr_q, addr_next;
    logic              lookup_go;
    logic              addr_wr, data_wr;
    logic              lk_present, lk_in_range, wr_present, wr_in_range;
    logic [SLOT_W-1:0] lk_slot, wr_slot;
    logic [3:0]        wr_be;
    logic [31:0]       wr_data, rd_data;
    logic [31:0]       resp_q, status_q;

    // Split the strobe by port.
    always_comb begin
        addr_wr = io_wr && !io_port_sel;
        data_wr = io_wr && io_port_sel;
    end

    cfgp_addr_reg u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (addr_wr),
        .lane       (io_lane),
        .size       (io_size),
        .wdata      (io_wdata),
        .addr_q     (addr_q),
        .addr_next  (addr_next),
        .lookup_go  (lookup_go),
        .reset_pulse(sys_reset_req)
    );

    cfgp_func_decode #(
        .NUM_SLOTS   (NUM_SLOTS),
        .SPACE_DWORDS(SPACE_DWORDS),
        .SLOT_W      (SLOT_W),
        .PRESENT_MASK(PRESENT_MASK)
    ) u_dec_lookup (
        .bdf     (addr_next[23:8]),
        .dword   (addr_next[7:2]),
        .present (lk_present),
        .slot    (lk_slot),
        .in_range(lk_in_range)
    );

    cfgp_func_decode #(
        .NUM_SLOTS   (NUM_SLOTS),
        .SPACE_DWORDS(SPACE_DWORDS),
        .SLOT_W      (SLOT_W),
        .PRESENT_MASK(PRESENT_MASK)
    ) u_dec_write (
        .bdf     (addr_q[23:8]),
        .dword   (addr_q[7:2]),
        .present (wr_present),
        .slot    (wr_slot),
        .in_range(wr_in_range)
    );

    cfgp_write_shaper u_shape (
        .lane (io_lane),
        .size (io_size),
        .wdata(io_wdata),
        .be   (wr_be),
        .data (wr_data)
    );

    cfgp_space_mem #(
        .NUM_SLOTS   (NUM_SLOTS),
        .SPACE_DWORDS(SPACE_DWORDS),
        .SLOT_W      (SLOT_W),
        .DW_W        (DW_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_wr && wr_present && wr_in_range),
        .wr_slot (wr_slot),
        .wr_dword(addr_q[2 +: DW_W]),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_slot (lk_slot),
        .rd_dword(addr_next[2 +: DW_W]),
        .rd_data (rd_data)
    );

    // Capture response and status when a lookup is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q   <= '0;
            status_q <= '0;
        end else if (lookup_go) begin
            if (lk_present) begin
                status_q <= STATUS_FOUND;
                resp_q   <= lk_in_range ? rd_data : 32'h0;
            end else begin
                status_q <= 32'h0;
                resp_q   <= RESP_NONE;
            end
        end
    end

    // Return the selected word aligned to the read lane.
    always_comb io_rdata = (io_port_sel ? resp_q : status_q) >> {io_lane, 3'b000};

endmodule

// File: rtl/cfgp_port_ctrl_checker.sv
// Property checker for cfgp_port_ctrl, attached by bind below.
module cfgp_port_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic        io_port_sel,
    input logic [1:0]  io_lane,
    input logic [1:0]  io_size,
    input logic [23:0] addr_q,
    input logic [31:0] resp_q,
    input logic [31:0] status_q,
    input logic        lookup_go,
    input logic        sys_reset_req
);

    logic [2:0] nbytes;

    // Width of the current access in bytes.
    always_comb nbytes = (io_size == 2'd2) ? 3'd4 : (io_size == 2'd1) ? 3'd2 : 3'd1;

    a_r1_offset_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q[1:0] == 2'b00);

    a_r2_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_go |=> ($stable(resp_q) && $stable(status_q)));

    a_r3_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == 32'h0) || (status_q == 32'h8000_0000));

    a_r4_absent_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_go |=> (status_q[31] || (resp_q == 32'hFFFF_FFFF)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    a_r6_byte1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> (addr_q[15:8] == $past(addr_q[15:8])));

    a_r7_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> (io_size != 2'd3));

    a_r7_half_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port_sel && io_size == 2'd1) |-> !io_lane[0]);

    a_r7_word_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port_sel && io_size == 2'd2) |-> (io_lane == 2'd0));

    a_r6_addr_fit: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_port_sel) |-> (({1'b0, io_lane} + nbytes) <= 3'd4));

endmodule

bind cfgp_port_ctrl cfgp_port_ctrl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_wr        (io_wr),
    .io_port_sel  (io_port_sel),
    .io_lane      (io_lane),
    .io_size      (io_size),
    .addr_q       (addr_q),
    .resp_q       (resp_q),
    .status_q     (status_q),
    .lookup_go    (lookup_go),
    .sys_reset_req(sys_reset_req)
);

// File: tb/cfgp_port_ctrl_bench.sv
module cfgp_port_ctrl_bench;
    import cfgp_pkg::*;

    localparam int         NS   = 4;
    localparam int         SD   = 32;
    localparam logic [3:0] MASK = 4'b1011;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        io_wr = 1'b0, io_port_sel = 1'b0;
    logic [1:0]  io_lane = 2'd0, io_size = 2'd0;
    logic [31:0] io_wdata = 32'h0;
    logic [31:0] io_rdata;
    logic        sys_reset_req;

    always #2 clk = ~clk;

    cfgp_port_ctrl #(.NUM_SLOTS(NS), .SPACE_DWORDS(SD), .PRESENT_MASK(MASK)) u_cfgp_port_ctrl (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port_sel(io_port_sel),
        .io_lane(io_lane), .io_size(io_size), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .sys_reset_req(sys_reset_req)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R9";
    bit    done = 1'b0;

    // Behavioural reference state
    logic [7:0]  m_a0, m_a1, m_a2;
    logic [31:0] m_resp, m_stat;
    logic        m_pulse;
    logic [31:0] m_mem [NS][SD];

    function automatic bit m_present(input logic [15:0] bdf);
        int dev;
        dev = int'(bdf[7:3]);
        return (bdf[15:8] == 8'h00) && (bdf[2:0] == 3'b000) && (dev < NS) && MASK[dev];
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
        end
    endtask

    // Reference update at a clock edge from the driven inputs.
    task automatic m_edge();
        int nb, pos, off, dw, dev;
        logic [7:0]  bt;
        logic [15:0] bdf;
        m_pulse = 1'b0;
        if (!rst_n) begin
            m_a0 = 0; m_a1 = 0; m_a2 = 0; m_resp = 0; m_stat = 0;
            for (int s = 0; s < NS; s++) for (int d = 0; d < SD; d++) m_mem[s][d] = 0;
            return;
        end
        if (!io_wr) return;
        nb = (io_size == IO_WORD) ? 4 : (io_size == IO_HALF) ? 2 : 1;
        if (!io_port_sel) begin
            for (int k = 0; k < nb; k++) begin
                bt  = io_wdata[8*k +: 8];
                pos = int'(io_lane) + k;
                if (pos == 0) m_a0 = bt & 8'hFC;
                else if (pos == 1) begin
                    if (m_a1[2:1] == 2'b01 && bt[2:1] == 2'b11) m_pulse = 1'b1;
                    else m_a1 = bt;
                end else if (pos == 2) m_a2 = bt;
            end
            if (int'(io_lane) + nb == 4) begin
                bdf = {m_a2, m_a1};
                if (m_present(bdf)) begin
                    dev = int'(bdf[7:3]);
                    dw  = int'(m_a0) / 4;
                    m_stat = 32'h8000_0000;
                    m_resp = (dw < SD) ? m_mem[dev][dw] : 32'h0;
                end else begin
                    m_stat = 32'h0;
                    m_resp = 32'hFFFF_FFFF;
                end
            end
        end else begin
            bdf = {m_a2, m_a1};
            off = int'(m_a0) + int'(io_lane);
            dw  = off / 4;
            if (m_present(bdf) && dw < SD) begin
                dev = int'(bdf[7:3]);
                for (int k = 0; k < nb; k++) m_mem[dev][dw][8*((off % 4) + k) +: 8] = io_wdata[8*k +: 8];
            end
        end
    endtask

    // One clock: update reference at the edge, compare outputs at the falling edge.
    task automatic tick();
        logic [31:0] exp_rd;
        @(posedge clk);
        m_edge();
        @(negedge clk);
        exp_rd = (io_port_sel ? m_resp : m_stat) >> (8 * int'(io_lane));
        chk(io_rdata, exp_rd, "rdata vs model");
        chk({31'b0, sys_reset_req}, {31'b0, m_pulse}, "reset request vs model");
    endtask

    task automatic acc(input logic sel, input logic [1:0] lane, input logic [1:0] size, input logic [31:0] data);
        io_wr = 1'b1; io_port_sel = sel; io_lane = lane; io_size = size; io_wdata = data;
        tick();
        io_wr = 1'b0;
    endtask

    task automatic lit(input logic sel, input logic [1:0] lane, input logic [31:0] exp, input string what);
        io_wr = 1'b0; io_port_sel = sel; io_lane = lane;
        tick();
        chk(io_rdata, exp, what);
    endtask

    task automatic set_addr(input logic [31:0] a);
        acc(1'b0, 2'd0, IO_WORD, a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        cur_req = "R9";
        repeat (3) tick();
        rst_n = 1'b1;
        lit(1'b0, 2'd0, 32'h0, "status after reset");
        lit(1'b1, 2'd0, 32'h0, "response after reset");
        chk({31'b0, sys_reset_req}, 32'h0, "reset request idle");

        // R3 / R7: full dword write and readback
        cur_req = "R3";
        set_addr(32'h8000_0008);
        acc(1'b1, 2'd0, IO_WORD, 32'hA5A5_1234);
        set_addr(32'h8000_0008);
        lit(1'b1, 2'd0, 32'hA5A5_1234, "present response");
        lit(1'b0, 2'd0, 32'h8000_0000, "present status");

        // R8: lane reads
        cur_req = "R8";
        lit(1'b1, 2'd1, 32'h00A5_A512, "data lane 1");
        lit(1'b1, 2'd3, 32'h0000_00A5, "data lane 3");
        lit(1'b0, 2'd3, 32'h0000_0080, "status lane 3");

        // R7: byte and 16-bit writes; R2: response stale until relookup
        cur_req = "R7";
        acc(1'b1, 2'd1, IO_BYTE, 32'h0000_0077);
        acc(1'b1, 2'd2, IO_HALF, 32'h0000_BEEF);
        acc(1'b1, 2'd3, IO_BYTE, 32'h0000_0011);
        cur_req = "R2";
        lit(1'b1, 2'd0, 32'hA5A5_1234, "response unchanged by data writes");
        acc(1'b0, 2'd0, IO_BYTE, 32'h0000_0000);
        acc(1'b0, 2'd1, IO_BYTE, 32'h0000_0008);
        lit(1'b1, 2'd0, 32'hA5A5_1234, "response unchanged by low address lanes");
        cur_req = "R7";
        set_addr(32'h8000_0008);
        lit(1'b1, 2'd0, 32'h11EF_7734, "merged lanes");

        // Other slots
        cur_req = "R3";
        set_addr(32'h8000_0840);
        acc(1'b1, 2'd0, IO_WORD, 32'hCAFE_F00D);
        set_addr(32'h8000_187C);
        acc(1'b1, 2'd0, IO_WORD, 32'h0BAD_BEEF);
        set_addr(32'h8000_0840);
        lit(1'b1, 2'd0, 32'hCAFE_F00D, "slot 1 readback");

        // R1: low offset bits dropped
        cur_req = "R1";
        set_addr(32'h8000_1800);
        acc(1'b0, 2'd0, IO_BYTE, 32'h0000_007F);
        acc(1'b0, 2'd3, IO_BYTE, 32'h0000_0080);
        lit(1'b1, 2'd0, 32'h0BAD_BEEF, "unaligned offset byte");

        // R11: enable bit ignored
        cur_req = "R11";
        acc(1'b0, 2'd0, IO_BYTE, 32'h0000_0040);
        acc(1'b0, 2'd1, IO_BYTE, 32'h0000_0008);
        acc(1'b0, 2'd3, IO_BYTE, 32'h0000_0000);
        lit(1'b1, 2'd0, 32'hCAFE_F00D, "lookup with bit 31 clear");
        lit(1'b0, 2'd0, 32'h8000_0000, "status with bit 31 clear");

        // R4: absent cases
        cur_req = "R4";
        set_addr(32'h8000_1000);
        lit(1'b1, 2'd0, 32'hFFFF_FFFF, "masked slot response");
        lit(1'b0, 2'd0, 32'h0, "masked slot status");
        set_addr(32'h8000_2800);
        lit(1'b1, 2'd0, 32'hFFFF_FFFF, "device beyond table");
        set_addr(32'h8001_0008);
        lit(1'b1, 2'd0, 32'hFFFF_FFFF, "nonzero bus");
        set_addr(32'h8000_0108);
        lit(1'b1, 2'd0, 32'hFFFF_FFFF, "nonzero function");

        // R10: writes to absent functions dropped
        cur_req = "R10";
        acc(1'b1, 2'd0, IO_WORD, 32'hDEAD_0000);
        set_addr(32'h8001_0008);
        acc(1'b1, 2'd0, IO_WORD, 32'hDEAD_0001);
        set_addr(32'h8000_0008);
        lit(1'b1, 2'd0, 32'h11EF_7734, "slot 0 untouched");

        // R5: offset beyond space
        cur_req = "R5";
        set_addr(32'h8000_0088);
        lit(1'b1, 2'd0, 32'h0, "out-of-space response");
        lit(1'b0, 2'd0, 32'h8000_0000, "out-of-space status");
        acc(1'b1, 2'd0, IO_WORD, 32'h1234_5678);
        set_addr(32'h8000_0008);
        lit(1'b1, 2'd0, 32'h11EF_7734, "out-of-space write dropped");

        // R6: reset request pattern
        cur_req = "R6";
        set_addr(32'h8000_0200);
        acc(1'b0, 2'd1, IO_BYTE, 32'h0000_0006);
        chk({31'b0, sys_reset_req}, 32'h1, "pulse after pattern");
        lit(1'b1, 2'd0, 32'hFFFF_FFFF, "pulse lasts one cycle");
        chk({31'b0, sys_reset_req}, 32'h0, "pulse dropped");
        acc(1'b0, 2'd3, IO_BYTE, 32'h0000_0080);
        lit(1'b1, 2'd0, 32'hFFFF_FFFF, "byte 1 kept at 02");
        acc(1'b0, 2'd1, IO_BYTE, 32'h0000_0000);
        acc(1'b0, 2'd1, IO_BYTE, 32'h0000_0006);
        chk({31'b0, sys_reset_req}, 32'h0, "no pulse from prior 00");
        acc(1'b0, 2'd1, IO_BYTE, 32'h0000_0006);
        chk({31'b0, sys_reset_req}, 32'h0, "no pulse from prior 11");
        acc(1'b0, 2'd1, IO_BYTE, 32'h0000_0002);
        set_addr(32'h8000_0608);
        chk({31'b0, sys_reset_req}, 32'h1, "pulse from full-width write");
        lit(1'b1, 2'd0, 32'hFFFF_FFFF, "full-width lookup kept byte 1");
        set_addr(32'h8000_0008);
        lit(1'b1, 2'd0, 32'h11EF_7734, "address usable after pattern");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule